// File: doc/BRIEF.md
# External Bus Arbitration Controller

This block decides when an outside bus master may take the shared address, data and control bus away from the local processor, and when the bus comes back. The outside master raises an asynchronous request; the controller answers with a grant. The master then raises an asynchronous acknowledge to confirm it has taken the bus. From that point the controller asks the local pad drivers to float, but only once the local bus controller reports that no address strobe is active and no indivisible read-modify-write sequence is running. When the acknowledge drops, the local drivers are re-enabled in the same clock as the state change.

Requests are not honoured while an indivisible read-modify-write sequence is in progress. If the request line is still high when the acknowledge drops, it is taken as a second requester and the grant is raised again straight away. All internal logic is active high. Pin polarity conversion is left to the pad ring.

Top module: `bus_arbiter_ctl`

## Requirements
- R1: A clock edge with `rst_n` low clears both synchronizers and the state, so that `grant_o` and `float_o` read 0 after that edge; the state register never holds code 1 or code 4 (idle is 0, granted is 2, externally owned is 3).
- R2: `ext_req_i` and `ext_ack_i` each pass through a 2-flop synchronizer; a change on `ext_req_i` has no effect on `grant_o` after 3 edges.
- R3: While idle, with request and acknowledge both low, the controller stays idle whatever `strobe_i` and `locked_i` do, and both outputs stay 0.
- R4: From idle with `locked_i` low, a request raises `grant_o` after the 4th rising edge (2 synchronizer edges, 1 state edge, 1 output register edge).
- R5: In the granted state, an acknowledge moves the controller to externally owned on the 3rd edge, and `grant_o` falls after the 4th edge; `grant_o` and `float_o` are never both 1.
- R6: In the owned state, `float_o` rises after the first edge on which `strobe_i` and `locked_i` are both sampled low, and not before.
- R7: When the acknowledge falls with no request pending, the controller returns to idle on the 3rd edge and `float_o` is 0 right after that same edge.
- R8: When the acknowledge falls with the request still high, the controller moves straight to granted on the 3rd edge, with `float_o` 0 after that edge and `grant_o` 1 after the 4th.
- R9: While idle and `locked_i` is high, a request is not granted; once `locked_i` falls with the request already synchronized, `grant_o` rises after the 2nd edge.
- R10: If the request drops in the granted state before any acknowledge, the controller returns to idle on the 3rd edge and `grant_o` falls after the 4th.
- R11: An acknowledge seen while idle moves the controller directly to owned, and the float rules of R6 apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master, active high |
| ext_ack_i | input | 1 | Asynchronous grant acknowledge from the outside master, active high |
| strobe_i | input | 1 | Local address strobe active, synchronous |
| locked_i | input | 1 | Local read-modify-write sequence in progress, synchronous |
| grant_o | output | 1 | Registered bus grant to the outside master |
| float_o | output | 1 | Tri-state enable for the local address, data and control drivers |

## Verification
Every result has a fixed edge count from its stimulus. A request or acknowledge change reaches the state after 3 edges, and `grant_o` follows after 4. `float_o` falls on the 3rd edge after the acknowledge drops and rises on the 4th, or on the first edge after strobe and lock clear. A lock release lets the grant through after 2 edges. The bench drives inputs on the falling edge and samples outputs on a later falling edge. Each table row gives the exact number of rising edges to wait, so every check lands one edge short of a change and again on it.

// File: rtl/arb_pkg.sv
// Package: shared types for the external bus arbitration controller.
// Assumes: 3-bit state codes; codes 1 and 4 are left unused by design.
package arb_pkg;
    localparam int ARB_STATE_W = 3;

    typedef enum logic [ARB_STATE_W-1:0] {
        ARB_IDLE  = 3'd0,
        ARB_GRANT = 3'd2,
        ARB_OWNED = 3'd3
    } arb_state_e;
endpackage

// File: rtl/arb_sync.sv
// Module: arb_sync
// Multi-bit, multi-stage flop synchronizer for independent asynchronous
// single-bit inputs. Assumes each bit is a level that is held well over
// one clock period; it gives no coherence between bits.
module arb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [LAST:0] chain_q;

        // Shift the raw level through the chain, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[LAST-1:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end
endmodule

// File: rtl/arb_fsm.sv
// Module: arb_fsm
// Arbitration state machine. Moves between idle, granted and externally
// owned on synchronized request/acknowledge. Assumes req_s/ack_s are
// already synchronous. Unused codes fall back to idle.
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       ack_s,
    input  logic       locked_i,
    output arb_state_e state_o
);
    arb_state_e state_q;
    arb_state_e state_d;

    // Next-state decision from the synchronized inputs and the lock.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (ack_s) begin
                    state_d = ARB_OWNED;
                end else if (req_s && !locked_i) begin
                    state_d = ARB_GRANT;
                end
            end
            ARB_GRANT: begin
                if (ack_s) begin
                    state_d = ARB_OWNED;
                end else if (!req_s) begin
                    state_d = ARB_IDLE;
                end
            end
            ARB_OWNED: begin
                if (!ack_s) begin
                    state_d = req_s ? ARB_GRANT : ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/arb_float.sv
// Module: arb_float
// Float control for the local drivers. Sets a flag once the owned state
// sees strobe and lock both clear, and holds it while ownership lasts.
// The output is gated by the owned state, so drivers come back in the
// same cycle the state leaves owned.
module arb_float (
    input  logic clk,
    input  logic rst_n,
    input  logic owned_i,
    input  logic strobe_i,
    input  logic locked_i,
    output logic float_o
);
    logic float_q;
    logic bus_quiet;

    assign bus_quiet = !strobe_i && !locked_i;

    // Arm the float once the local bus is quiet during ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            float_q <= 1'b0;
        end else begin
            float_q <= owned_i && (float_q || bus_quiet);
        end
    end

    assign float_o = float_q && owned_i;
endmodule

// File: rtl/bus_arbiter_ctl.sv
// Module: bus_arbiter_ctl (top)
// External bus arbitration controller: synchronizes the outside request
// and acknowledge, runs the arbitration state machine, registers the
// grant and drives the local tri-state enable. Assumes strobe_i and
// locked_i are synchronous to clk.
module bus_arbiter_ctl
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_i,
    input  logic ext_ack_i,
    input  logic strobe_i,
    input  logic locked_i,
    output logic grant_o,
    output logic float_o
);
    localparam int N_ASYNC = 2;
    localparam int IDX_REQ = 0;
    localparam int IDX_ACK = 1;

    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] sync_in;
    logic               req_s;
    logic               ack_s;
    arb_state_e         state_q;
    logic               grant_q;

    assign raw_in[IDX_REQ] = ext_req_i;
    assign raw_in[IDX_ACK] = ext_ack_i;

    arb_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign req_s = sync_in[IDX_REQ];
    assign ack_s = sync_in[IDX_ACK];

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (req_s),
        .ack_s    (ack_s),
        .locked_i (locked_i),
        .state_o  (state_q)
    );

    // Grant pin lags the granted state by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
        end else begin
            grant_q <= (state_q == ARB_GRANT);
        end
    end

    assign grant_o = grant_q;

    arb_float u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .owned_i  (state_q == ARB_OWNED),
        .strobe_i (strobe_i),
        .locked_i (locked_i),
        .float_o  (float_o)
    );
endmodule

// File: rtl/bus_arbiter_ctl_chk.sv
// Module: bus_arbiter_ctl_chk
// Property checker bound into bus_arbiter_ctl. Observes ports plus the
// synchronized inputs and state register.
module bus_arbiter_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic       req_s,
    input logic       ack_s,
    input logic       strobe_i,
    input logic       locked_i,
    input logic       grant_o,
    input logic       float_o
);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 3'd1) && (state != 3'd4));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0) && !req_s && !ack_s |=> (state == 3'd0));

    assert_grant_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(req_s, 2));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && float_o));

    assert_float_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(float_o) |-> $past(!strobe_i && !locked_i));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3) && !ack_s |=> !float_o);

    assert_regrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3) && !ack_s && req_s |=> (state == 3'd2));

    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0) && locked_i |=> (state != 3'd2));
endmodule

bind bus_arbiter_ctl bus_arbiter_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .req_s    (req_s),
    .ack_s    (ack_s),
    .strobe_i (strobe_i),
    .locked_i (locked_i),
    .grant_o  (grant_o),
    .float_o  (float_o)
);

// File: tb/bus_arbiter_ctl_bench.sv
// Bench for bus_arbiter_ctl: a vector table walked by one loop, then
// directed reset cases. Inputs change on falling edges; outputs are
// sampled on falling edges after a counted number of rising edges.
module bus_arbiter_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req_i = 1'b0;
    logic ext_ack_i = 1'b0;
    logic strobe_i = 1'b0;
    logic locked_i = 1'b0;
    logic grant_o;
    logic float_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    bus_arbiter_ctl u_bus_arbiter_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req_i (ext_req_i),
        .ext_ack_i (ext_ack_i),
        .strobe_i  (strobe_i),
        .locked_i  (locked_i),
        .grant_o   (grant_o),
        .float_o   (float_o)
    );

    typedef struct packed {
        logic       req;
        logic       ack;
        logic       strb;
        logic       lock;
        logic [7:0] edges;
        logic       exp_g;
        logic       exp_f;
        logic [7:0] rnum;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 8'd2 },  // R2 too early
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 8'd4 },  // R4 grant
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 1'b1, 1'b0, 8'd5 },  // R5 owned, grant lags
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1, 8'd5 },  // R5 grant off, float on
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 1'b0, 1'b1, 8'd7 },  // R7 not yet
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 8'd7 },  // R7 released
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 1'b0, 1'b0, 8'd9 },  // R9 locked out
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 8'd9 },  // R9 state edge
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 8'd9 },  // R9 grant
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd4, 1'b0, 1'b0, 8'd6 },  // R6 strobe holds
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1, 8'd6 },  // R6 floats
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 8'd8 },  // R8 drivers back
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 8'd8 },  // R8 regrant
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 1'b1, 1'b0, 8'd10},  // R10 lag
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 8'd10},  // R10 withdrawn
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd4, 1'b0, 1'b0, 8'd11},  // R11 owned, lock holds
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 1'b0, 1'b1, 8'd11},  // R11 floats
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 8'd7 },  // R7 release from R11
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd6, 1'b0, 1'b0, 8'd3 },  // R3 strobe idle
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd4, 1'b0, 1'b0, 8'd3 }   // R3 lock idle
    };

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic eg, input logic ef);
        n_tests++;
        if (grant_o !== eg || float_o !== ef) begin
            n_fail++;
            $display("FAIL %s: grant_o=%b float_o=%b expected grant_o=%b float_o=%b",
                     tag, grant_o, float_o, eg, ef);
        end
    endtask

    task automatic drive(input logic rq, input logic ak, input logic sb, input logic lk);
        ext_req_i = rq;
        ext_ack_i = ak;
        strobe_i  = sb;
        locked_i  = lk;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_edges(3);
        check("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].req, VECS[i].ack, VECS[i].strb, VECS[i].lock);
            wait_edges(int'(VECS[i].edges));
            check($sformatf("R%0d vec%0d", VECS[i].rnum, i), VECS[i].exp_g, VECS[i].exp_f);
        end

        // R1: reset while granted
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        wait_edges(4);
        check("R4 grant before reset", 1'b1, 1'b0);
        rst_n = 1'b0;
        wait_edges(1);
        check("R1 reset drops grant", 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_edges(3);
        check("R2 resync after reset", 1'b0, 1'b0);
        wait_edges(1);
        check("R4 regrant after reset", 1'b1, 1'b0);

        // R1: reset while floating
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        wait_edges(4);
        check("R5 floating before reset", 1'b0, 1'b1);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        wait_edges(1);
        check("R1 reset drops float", 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_edges(4);
        check("R3 idle after reset", 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule